// File: doc/BRIEF.md
# Weighted Spectral Peak Frequency Tracker

The tracker consumes one transform frame of magnitude values per pass, one bin per accepted transfer, from bin 0 to bin 4095 in order. Inside a limited search window it keeps the strongest bin and that bin's two neighbours. When the final bin of the frame has been taken, it computes the neighbour-weighted centroid of the peak with a small serial divider. The result is a bin index with eight fraction bits. It turns that index into a 32-bit phase-increment word for the oscillator that steers the downconverters.

The centroid usually falls between bins, so the oscillator is tuned more finely than the bin spacing allows. Each frame is evaluated on its own, so a carrier that hops by small steps is followed from one frame to the next. The output frequency equals the sample rate times the fractional index divided by 4096. Because the word is scaled by 2^32/4096, the sample rate cancels out of the arithmetic.

The input is a valid/ready stream. A bin transfers only in a cycle where `in_valid` and `in_ready` are both high. While the centroid is being computed, `in_ready` stays low, and the upstream source must hold its current bin until `in_ready` returns. The result is a one-cycle strobe with no back-pressure.

Top module: `spectral_peak_tracker`

## Requirements
- R1: After reset, `out_valid` is 0, `out_peak_idx`, `out_frac_idx` and `out_tune_word` are 0, and `in_ready` is 1.
- R2: A bin is consumed only in a cycle with `in_valid` and `in_ready` both high. From the cycle after bin 4095 is consumed, `in_ready` is 0 until the result is delivered.
- R3: Only bins 0 to 1750 take part in the search. Larger magnitudes at higher bins have no effect on any output.
- R4: The peak is the bin with the largest magnitude in the window. On a tie, the lowest index wins.
- R5: The fractional index is k·256 + q for peak k with left, centre and right magnitudes L, C and R. Here q is (R−L)·256/(L+C+R), rounded to the nearest integer with halves away from zero. When L+C+R is 0, q is 0.
- R6: A peak at bin 0 takes L as 0. A peak at bin 1750 takes R as 0.
- R7: The tuning word is the fractional index shifted left by 12 bits, which equals round(index × 2^32 / 4096).
- R8: Each completed frame gives exactly one one-cycle `out_valid` pulse, no later than 16 cycles after bin 4095 is consumed. Between pulses, all result outputs hold their values.
- R9: A transfer with `in_sof` high restarts the search. It discards whatever a previous incomplete frame left behind.
- R10: Consecutive frames are evaluated independently, so a peak that moves by a few bins between frames is reported at its new position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bin on the input is valid |
| in_ready | output | 1 | Tracker can accept a bin |
| in_sof | input | 1 | Marks the first bin of a frame |
| in_bin | input | 12 | Bin index, 0 to 4095 in order |
| in_mag | input | 16 | Unsigned bin magnitude |
| out_valid | output | 1 | One-cycle result strobe |
| out_peak_idx | output | 12 | Integer peak bin |
| out_frac_idx | output | 20 | Peak index with 8 fraction bits |
| out_tune_word | output | 32 | Oscillator phase increment |

## Verification
The hardest conditions to reach are the window edges. One is a peak sitting on bin 1750 while a much larger value lies on bin 1751. The other is a peak on bin 0, where no left neighbour exists. Dedicated frames place the peak on each edge and put decoys just outside the window. A separate frame makes (R−L)·256/(L+C+R) land exactly on one half, which checks the rounding direction. Another sends a partial frame with a dominant decoy and then restarts with a start-of-frame marker, so any leftover state would show up in the next result.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    DV_IDLE,
    DV_PREP,
    DV_STEP,
    DV_FIN
  } div_state_e;
endpackage

// File: rtl/spt_peak_search.sv
module spt_peak_search #(
  parameter int BIN_W      = 12,
  parameter int MAG_W      = 16,
  parameter int SEARCH_MAX = 1750
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sof,
  input  logic [BIN_W-1:0] bin,
  input  logic [MAG_W-1:0] mag,
  output logic [BIN_W-1:0] peak_idx,
  output logic [MAG_W-1:0] peak_mag,
  output logic [MAG_W-1:0] left_mag,
  output logic [MAG_W-1:0] right_mag
);
  localparam logic [BIN_W-1:0] WIN_LAST = BIN_W'(SEARCH_MAX);

  logic [MAG_W-1:0] prev_mag;
  logic             want_right;
  logic             in_window;
  logic             take;

  assign in_window = (bin <= WIN_LAST);
  assign take      = sof || (in_window && (mag > peak_mag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mag   <= '0;
      peak_idx   <= '0;
      peak_mag   <= '0;
      left_mag   <= '0;
      right_mag  <= '0;
      want_right <= 1'b0;
    end else if (accept) begin
      prev_mag <= mag;
      if (take) begin
        peak_idx   <= bin;
        peak_mag   <= mag;
        left_mag   <= (sof || bin == '0) ? '0 : prev_mag;
        right_mag  <= '0;
        want_right <= (bin != WIN_LAST);
      end else if (want_right) begin
        right_mag  <= mag;
        want_right <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spt_centroid_div.sv
module spt_centroid_div
  import spt_pkg::*;
#(
  parameter int BIN_W  = 12,
  parameter int MAG_W  = 16,
  parameter int FRAC_W = 8,
  localparam int FIDX_W = BIN_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BIN_W-1:0]  peak_idx,
  input  logic [MAG_W-1:0]  left_mag,
  input  logic [MAG_W-1:0]  ctr_mag,
  input  logic [MAG_W-1:0]  right_mag,
  output logic              busy,
  output logic              done,
  output logic [FIDX_W-1:0] frac_idx
);
  localparam int SUM_W = MAG_W + 2;
  localparam int QB    = FRAC_W + 1;
  localparam int CNT_W = $clog2(QB + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FRAC_W);

  div_state_e       st;
  logic [SUM_W-1:0] den;
  logic [SUM_W-1:0] rem;
  logic [SUM_W:0]   trial;
  logic [QB-1:0]    quo;
  logic [CNT_W-1:0] cnt;
  logic             neg;
  logic [QB:0]      q_round;
  logic [FIDX_W-1:0] base;
  logic [FIDX_W-1:0] offs;
  logic             fits;

  assign busy    = (st != DV_IDLE);
  assign trial   = {rem, 1'b0};
  assign fits    = (den != '0) && (trial >= {1'b0, den});
  assign q_round = ({1'b0, quo} + 1'b1) >> 1;
  assign base    = {peak_idx, {FRAC_W{1'b0}}};
  assign offs    = FIDX_W'(q_round);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DV_IDLE;
      den      <= '0;
      rem      <= '0;
      quo      <= '0;
      cnt      <= '0;
      neg      <= 1'b0;
      done     <= 1'b0;
      frac_idx <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        DV_IDLE: if (start) st <= DV_PREP;
        DV_PREP: begin
          den <= SUM_W'(left_mag) + SUM_W'(ctr_mag) + SUM_W'(right_mag);
          if (right_mag >= left_mag) begin
            rem <= SUM_W'(right_mag - left_mag);
            neg <= 1'b0;
          end else begin
            rem <= SUM_W'(left_mag - right_mag);
            neg <= 1'b1;
          end
          quo <= '0;
          cnt <= '0;
          st  <= DV_STEP;
        end
        DV_STEP: begin
          if (fits) begin
            rem <= SUM_W'(trial - {1'b0, den});
            quo <= {quo[QB-2:0], 1'b1};
          end else begin
            rem <= SUM_W'(trial);
            quo <= {quo[QB-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST_STEP) st <= DV_FIN;
        end
        DV_FIN: begin
          frac_idx <= neg ? (base - offs) : (base + offs);
          done     <= 1'b1;
          st       <= DV_IDLE;
        end
        default: st <= DV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spt_tune_word.sv
module spt_tune_word #(
  parameter int BIN_W  = 12,
  parameter int FRAC_W = 8,
  parameter int TW_W   = 32,
  localparam int FIDX_W = BIN_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [BIN_W-1:0]  peak_idx,
  input  logic [FIDX_W-1:0] frac_idx,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_idx,
  output logic [FIDX_W-1:0] out_frac,
  output logic [TW_W-1:0]   out_tw
);
  localparam int SHIFT = TW_W - FIDX_W;

  logic [TW_W-1:0] tw_next;

  generate
    if (SHIFT >= 0) begin : g_widen
      assign tw_next = TW_W'(frac_idx) << SHIFT;
    end else begin : g_narrow
      localparam int DN = -SHIFT;
      logic [FIDX_W:0] rnd;
      assign rnd     = {1'b0, frac_idx} + ((FIDX_W + 1)'(1) << (DN - 1));
      assign tw_next = TW_W'(rnd >> DN);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_frac  <= '0;
      out_tw    <= '0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_idx  <= peak_idx;
        out_frac <= frac_idx;
        out_tw   <= tw_next;
      end
    end
  end
endmodule

// File: rtl/spectral_peak_tracker.sv
module spectral_peak_tracker #(
  parameter int FFT_LEN    = 4096,
  parameter int MAG_W      = 16,
  parameter int SEARCH_MAX = 1750,
  parameter int FRAC_W     = 8,
  parameter int TW_W       = 32,
  localparam int BIN_W     = $clog2(FFT_LEN),
  localparam int FIDX_W    = BIN_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [BIN_W-1:0]  in_bin,
  input  logic [MAG_W-1:0]  in_mag,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_peak_idx,
  output logic [FIDX_W-1:0] out_frac_idx,
  output logic [TW_W-1:0]   out_tune_word
);
  localparam logic [BIN_W-1:0] FRAME_LAST = BIN_W'(FFT_LEN - 1);

  logic              accept;
  logic              start;
  logic              busy;
  logic              done;
  logic [BIN_W-1:0]  pk_idx;
  logic [MAG_W-1:0]  pk_mag;
  logic [MAG_W-1:0]  lf_mag;
  logic [MAG_W-1:0]  rt_mag;
  logic [FIDX_W-1:0] frac;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign start    = accept && (in_bin == FRAME_LAST);

  spt_peak_search #(
    .BIN_W(BIN_W), .MAG_W(MAG_W), .SEARCH_MAX(SEARCH_MAX)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof),
    .bin(in_bin), .mag(in_mag), .peak_idx(pk_idx), .peak_mag(pk_mag),
    .left_mag(lf_mag), .right_mag(rt_mag)
  );

  spt_centroid_div #(
    .BIN_W(BIN_W), .MAG_W(MAG_W), .FRAC_W(FRAC_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .peak_idx(pk_idx),
    .left_mag(lf_mag), .ctr_mag(pk_mag), .right_mag(rt_mag),
    .busy(busy), .done(done), .frac_idx(frac)
  );

  spt_tune_word #(
    .BIN_W(BIN_W), .FRAC_W(FRAC_W), .TW_W(TW_W)
  ) u_tw (
    .clk(clk), .rst_n(rst_n), .done(done), .peak_idx(pk_idx),
    .frac_idx(frac), .out_valid(out_valid), .out_idx(out_peak_idx),
    .out_frac(out_frac_idx), .out_tw(out_tune_word)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int FFT_LEN    = 4096,
  parameter int SEARCH_MAX = 1750,
  parameter int FRAC_W     = 8,
  parameter int TW_W       = 32,
  localparam int BIN_W     = $clog2(FFT_LEN),
  localparam int FIDX_W    = BIN_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BIN_W-1:0]  in_bin,
  input logic              out_valid,
  input logic [BIN_W-1:0]  out_peak_idx,
  input logic [FIDX_W-1:0] out_frac_idx,
  input logic [TW_W-1:0]   out_tune_word
);
  localparam int ONE  = 1 << FRAC_W;
  localparam int HALF = ONE / 2;
  localparam logic [BIN_W-1:0] FRAME_LAST = BIN_W'(FFT_LEN - 1);

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bin == FRAME_LAST) |=> !in_ready); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_tune_word) && $stable(out_frac_idx))); // R8
  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_peak_idx) <= SEARCH_MAX)); // R3
  AST_FRAC_NEAR_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((int'(out_frac_idx) + HALF >= int'(out_peak_idx) * ONE) &&
                   (int'(out_frac_idx) <= int'(out_peak_idx) * ONE + HALF))); // R5
endmodule

bind spectral_peak_tracker spt_checker #(
  .FFT_LEN(FFT_LEN), .SEARCH_MAX(SEARCH_MAX), .FRAC_W(FRAC_W), .TW_W(TW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bin(in_bin), .out_valid(out_valid), .out_peak_idx(out_peak_idx),
  .out_frac_idx(out_frac_idx), .out_tune_word(out_tune_word)
);

// File: tb/tb_spectral_peak_tracker.sv
module tb_spectral_peak_tracker;
  localparam int NBINS = 4096;
  localparam int WMAX  = 1750;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic [11:0] in_bin = '0;
  logic [15:0] in_mag = '0;
  logic        out_valid;
  logic [11:0] out_peak_idx;
  logic [19:0] out_frac_idx;
  logic [31:0] out_tune_word;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spectral_peak_tracker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_bin(in_bin), .in_mag(in_mag), .out_valid(out_valid),
    .out_peak_idx(out_peak_idx), .out_frac_idx(out_frac_idx),
    .out_tune_word(out_tune_word)
  );

  always @(negedge clk) if (out_valid) pulses++;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mag_of(input int pat, input int b);
    int v;
    v = (b * 37 + pat * 11) % 40;
    case (pat)
      0: begin if (b == 898) v = 100; if (b == 899) v = 1000;
               if (b == 900) v = 900; if (b == 2000) v = 60000; end
      1: begin if (b == 900) v = 900; if (b == 901) v = 1000;
               if (b == 902) v = 100; end
      2: begin if (b == 0) v = 500; if (b == 1) v = 300; end
      3: begin if (b == 1749) v = 400; if (b == 1750) v = 800;
               if (b == 1751) v = 5000; if (b == 3000) v = 65535; end
      4: v = 0;
      5: begin if (b == 300) v = 700; if (b == 1200) v = 700;
               if (b == 301) v = 50; end
      6: begin if (b == 100) v = 60000; end
      7: begin if (b == 499) v = 100; if (b == 500) v = 311;
               if (b == 501) v = 101; end
      default: ;
    endcase
    return v;
  endfunction

  task automatic reference(input int pat, output int k, output int fr, output longint tw);
    int best, l, c, r, s, d, ad, q9, q;
    best = -1;
    k = 0;
    for (int b = 0; b <= WMAX; b++) begin
      if (mag_of(pat, b) > best) begin
        best = mag_of(pat, b);
        k = b;
      end
    end
    c = best;
    l = (k > 0) ? mag_of(pat, k - 1) : 0;
    r = (k < WMAX) ? mag_of(pat, k + 1) : 0;
    s = l + c + r;
    d = r - l;
    ad = (d < 0) ? -d : d;
    q9 = (s == 0) ? 0 : (ad * 512) / s;
    q = (q9 + 1) / 2;
    fr = (d < 0) ? k * 256 - q : k * 256 + q;
    tw = (longint'(fr) * 4096) % 64'h1_0000_0000;
  endtask

  task automatic send_bins(input int pat, input int count, input bit gaps);
    for (int b = 0; b < count; b++) begin
      @(negedge clk);
      if (gaps && (b % 7 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof   = (b == 0);
      in_bin   = 12'(b);
      in_mag   = 16'(mag_of(pat, b));
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic run_frame(input int pat, input bit gaps, input string req);
    int k, fr, lat, p0;
    longint tw;
    reference(pat, k, fr, tw);
    p0 = pulses;
    send_bins(pat, NBINS, gaps);
    chk(in_ready == 1'b0, "R2", "in_ready while computing", in_ready, 0);
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat <= 16, "R8", "result latency", lat, 16);
    chk(int'(out_peak_idx) == k, req, "peak index", out_peak_idx, k);
    chk(int'(out_frac_idx) == fr, req, "fractional index", out_frac_idx, fr);
    chk(longint'(out_tune_word) == tw, "R7", "tuning word", out_tune_word, tw);
    repeat (4) @(negedge clk);
    chk(pulses - p0 == 1, "R8", "pulses per frame", pulses - p0, 1);
    chk(int'(out_frac_idx) == fr, "R8", "result held", out_frac_idx, fr);
    chk(in_ready == 1'b1, "R2", "in_ready after result", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready at reset", in_ready, 1);
    chk(out_tune_word == 32'd0, "R1", "tuning word at reset", out_tune_word, 0);
    chk(out_frac_idx == 20'd0 && out_peak_idx == 12'd0, "R1", "indices at reset",
        out_frac_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 1'b0, "R3");
    run_frame(1, 1'b0, "R10");
    run_frame(2, 1'b1, "R6");
    run_frame(3, 1'b0, "R6");
    run_frame(4, 1'b0, "R5");
    run_frame(5, 1'b1, "R4");
    run_frame(7, 1'b0, "R5");
    send_bins(6, 500, 1'b0);
    run_frame(0, 1'b0, "R9");
    summary();
  end
endmodule